// File: doc/BRIEF.md
# Plane-Aware Flash Status Read Generator

This block builds the word returned on a read from a two-plane flash array while an embedded program or erase may be running. Each plane carries its own polling state. A read that targets a busy plane gets status bits folded into the array word. A read that targets the other plane gets the array word unchanged, so one plane can be read while the other works.

The status pattern depends on what the addressed plane is doing. During a program, bit 7 is the inverse of the bit 7 that was loaded, but only at the address being programmed. During an erase, bit 7 reads 0. In both cases bit 6 flips on every finished read of the busy plane. Bit 2 flips on each read of a plane that is erasing or that holds a suspended erase. A read of the suspended sector itself returns 1 on bits 7 and 6 and the flipping bit 2. A separate output pulls the shared ready/busy line low while any plane is busy.

Decoding of plane and sector, and the sequencing of the operations, are done outside this block. The array word comes in on an input. The read strobe `rd_act` is high for the length of one read. A read counts as finished on the clock edge where a registered copy of the strobe sees it fall.

Top module: `flash_status_gen`

## Requirements
- R1: `rb_drive_low` is 1 whenever any bit of `pgm_busy` or `ers_busy` is 1, and 0 otherwise.
- R2: A read of a programming plane at the address equal to `pgm_addr` returns the inverse of `pgm_data[7]` on bit 7.
- R3: A read of a programming plane at any other address returns the array's bit 7 on bit 7.
- R4: A read of an erasing plane returns 0 on bit 7, unless it hits the suspended sector.
- R5: Bit 6 of a read from a busy plane (programming or erasing) is 0 on the first read after the plane becomes busy. It inverts after every finished read of that plane.
- R6: Bit 2 reads 1 on a programming plane that holds no suspended erase.
- R7: Bit 2 of a read from a plane that is erasing, or that holds a suspended erase, is 0 on the first such read. It inverts after every finished read of that plane.
- R8: A read of a plane that is idle returns `array_data` exactly. This also holds for a non-suspended sector of a plane whose only activity is a suspended erase.
- R9: A read whose plane and sector equal the suspended ones, while `sus_valid` is 1, returns 1 on bits 7 and 6 and the R7 toggle on bit 2. This takes priority over program status.
- R10: While a program runs in the plane that holds the suspended erase, bit 2 of reads from that plane follows the R7 toggle instead of reading 1.
- R11: After a plane has been idle for one clock, its toggle state is 0. The first read of a new operation therefore starts again at 0.
- R12: Toggle state advances only once per read, when the strobe falls. Holding `rd_act` high for several clocks gives a steady word, and reads of the other plane leave a plane's toggles unchanged.
- R13: In every status read, bits 15..8, 5..3, 1 and 0 equal `array_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_act | input | 1 | High for the duration of one read |
| rd_plane | input | PL_W | Plane of the read address |
| rd_sector | input | SECT_W | Sector of the read address |
| rd_addr | input | ADDR_W | Full read address |
| array_data | input | DATA_W | Stored word at the read address |
| pgm_busy | input | NPLANE | Per-plane program in progress |
| ers_busy | input | NPLANE | Per-plane erase running (not suspended) |
| pgm_addr | input | ADDR_W | Address of the word being programmed |
| pgm_data | input | DATA_W | Word being programmed |
| sus_valid | input | 1 | An erase is suspended |
| sus_plane | input | PL_W | Plane of the suspended erase |
| sus_sector | input | SECT_W | Sector of the suspended erase |
| rd_data | output | DATA_W | Word to drive on the data bus |
| rb_drive_low | output | 1 | Pull the ready/busy line low |

## Verification
Two functions can fall in the same read. One is the suspended-sector override, the other is program status in that plane: a program may run in the plane that holds the suspended sector. The bench sets up that state and reads both the suspended sector and another sector of the same plane. It then judges bit 2 against the flip history it tracks itself. A second collision is a toggle advance on the same edge that a plane goes idle. The bench provokes it by changing plane state right after a read and checking that the next operation starts at 0.

// File: rtl/flash_sts_pkg.sv
package flash_sts_pkg;

    // Bit lanes carrying status; neighbours decode these positions.
    localparam int POLL_BIT = 7;
    localparam int TOG_BIT  = 6;
    localparam int SUS_BIT  = 2;

    typedef enum logic [1:0] {
        K_ARRAY  = 2'd0,
        K_PGM    = 2'd1,
        K_ERS    = 2'd2,
        K_SUSHIT = 2'd3
    } sts_kind_t;

    typedef struct packed {
        logic pgm;
        logic ers;
        logic sus_here;
        logic sus_hit;
    } plane_ctx_t;

    function automatic sts_kind_t classify(input plane_ctx_t c);
        if (c.sus_hit)  return K_SUSHIT;
        if (c.ers)      return K_ERS;
        if (c.pgm)      return K_PGM;
        return K_ARRAY;
    endfunction

endpackage

// File: rtl/fsb_read_edge.sv
module fsb_read_edge (
    input  logic clk,
    input  logic rst,
    input  logic rd_act,
    output logic rd_end
);
    logic act_q;

    always_ff @(posedge clk) begin
        if (rst) act_q <= 1'b0;
        else     act_q <= rd_act;
    end

    assign rd_end = act_q & ~rd_act;
endmodule

// File: rtl/fsb_plane_toggle.sv
module fsb_plane_toggle #(
    parameter int PL_W = 1,
    parameter int PIDX = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pgm,
    input  logic            ers,
    input  logic            sus_here,
    input  logic            rd_end,
    input  logic [PL_W-1:0] rd_plane,
    output logic            tog6,
    output logic            tog2
);
    logic act6, act2, rd_hit;
    logic tog6_q, tog2_q;

    assign act6   = pgm | ers;
    assign act2   = ers | sus_here;
    assign rd_hit = rd_end && (rd_plane == PL_W'(PIDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            tog6_q <= 1'b0;
        end else if (!act6) begin
            tog6_q <= 1'b0;
        end else if (rd_hit) begin
            tog6_q <= ~tog6_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tog2_q <= 1'b0;
        end else if (!act2) begin
            tog2_q <= 1'b0;
        end else if (rd_hit) begin
            tog2_q <= ~tog2_q;
        end
    end

    assign tog6 = tog6_q;
    assign tog2 = tog2_q;

    // R5
    tog6_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (act6 && rd_hit) |=> (tog6_q != $past(tog6_q)));

    // R7
    tog2_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (act2 && rd_hit) |=> (tog2_q != $past(tog2_q)));

    // R12
    tog_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (act6 && act2 && !rd_hit) |=> ($stable(tog6_q) && $stable(tog2_q)));

    // R11
    tog_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!act6 && !act2) |=> (!tog6_q && !tog2_q));
endmodule

// File: rtl/fsb_data_mux.sv
module fsb_data_mux
    import flash_sts_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 19,
    parameter int SECT_W = 5,
    parameter int NPLANE = 2,
    parameter int PL_W   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PL_W-1:0]   rd_plane,
    input  logic [SECT_W-1:0] rd_sector,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] array_data,
    input  logic [NPLANE-1:0] pgm_busy,
    input  logic [NPLANE-1:0] ers_busy,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic [DATA_W-1:0] pgm_data,
    input  logic              sus_valid,
    input  logic [PL_W-1:0]   sus_plane,
    input  logic [SECT_W-1:0] sus_sector,
    input  logic [NPLANE-1:0] tog6_vec,
    input  logic [NPLANE-1:0] tog2_vec,
    output logic [DATA_W-1:0] rd_data
);
    plane_ctx_t ctx;
    sts_kind_t  kind;
    logic       t6, t2;

    always_comb begin
        ctx.pgm      = pgm_busy[rd_plane];
        ctx.ers      = ers_busy[rd_plane];
        ctx.sus_here = sus_valid && (sus_plane == rd_plane);
        ctx.sus_hit  = ctx.sus_here && (rd_sector == sus_sector);
        kind         = classify(ctx);
        t6           = tog6_vec[rd_plane];
        t2           = tog2_vec[rd_plane];
    end

    always_comb begin
        rd_data = array_data;
        unique case (kind)
            K_SUSHIT: begin
                rd_data[POLL_BIT] = 1'b1;
                rd_data[TOG_BIT]  = 1'b1;
                rd_data[SUS_BIT]  = t2;
            end
            K_ERS: begin
                rd_data[POLL_BIT] = 1'b0;
                rd_data[TOG_BIT]  = t6;
                rd_data[SUS_BIT]  = t2;
            end
            K_PGM: begin
                if (rd_addr == pgm_addr)
                    rd_data[POLL_BIT] = ~pgm_data[POLL_BIT];
                rd_data[TOG_BIT] = t6;
                rd_data[SUS_BIT] = ctx.sus_here ? t2 : 1'b1;
            end
            default: ;
        endcase
    end

    // R4
    ers_poll_chk: assert property (@(posedge clk) disable iff (rst)
        (ers_busy[rd_plane] && !ctx.sus_hit) |-> !rd_data[POLL_BIT]);

    // R9
    sus_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (sus_valid && sus_plane == rd_plane && rd_sector == sus_sector)
        |-> (rd_data[POLL_BIT] && rd_data[TOG_BIT]));

    // R8
    idle_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!pgm_busy[rd_plane] && !ers_busy[rd_plane] && !ctx.sus_hit)
        |-> (rd_data == array_data));

    // R6
    pgm_sus_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (pgm_busy[rd_plane] && !ers_busy[rd_plane] && !ctx.sus_here)
        |-> rd_data[SUS_BIT]);
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import flash_sts_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 19,
    parameter int SECT_W = 5,
    parameter int NPLANE = 2,
    localparam int PL_W  = (NPLANE > 1) ? $clog2(NPLANE) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_act,
    input  logic [PL_W-1:0]   rd_plane,
    input  logic [SECT_W-1:0] rd_sector,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] array_data,
    input  logic [NPLANE-1:0] pgm_busy,
    input  logic [NPLANE-1:0] ers_busy,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic [DATA_W-1:0] pgm_data,
    input  logic              sus_valid,
    input  logic [PL_W-1:0]   sus_plane,
    input  logic [SECT_W-1:0] sus_sector,
    output logic [DATA_W-1:0] rd_data,
    output logic              rb_drive_low
);
    logic              rd_end;
    logic [NPLANE-1:0] tog6_vec;
    logic [NPLANE-1:0] tog2_vec;

    fsb_read_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .rd_act (rd_act),
        .rd_end (rd_end)
    );

    for (genvar p = 0; p < NPLANE; p++) begin : g_plane
        logic sus_here;
        assign sus_here = sus_valid && (sus_plane == PL_W'(p));

        fsb_plane_toggle #(.PL_W(PL_W), .PIDX(p)) u_tog (
            .clk      (clk),
            .rst      (rst),
            .pgm      (pgm_busy[p]),
            .ers      (ers_busy[p]),
            .sus_here (sus_here),
            .rd_end   (rd_end),
            .rd_plane (rd_plane),
            .tog6     (tog6_vec[p]),
            .tog2     (tog2_vec[p])
        );
    end

    fsb_data_mux #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SECT_W(SECT_W),
        .NPLANE(NPLANE), .PL_W(PL_W)
    ) u_mux (
        .clk        (clk),
        .rst        (rst),
        .rd_plane   (rd_plane),
        .rd_sector  (rd_sector),
        .rd_addr    (rd_addr),
        .array_data (array_data),
        .pgm_busy   (pgm_busy),
        .ers_busy   (ers_busy),
        .pgm_addr   (pgm_addr),
        .pgm_data   (pgm_data),
        .sus_valid  (sus_valid),
        .sus_plane  (sus_plane),
        .sus_sector (sus_sector),
        .tog6_vec   (tog6_vec),
        .tog2_vec   (tog2_vec),
        .rd_data    (rd_data)
    );

    // R1: any plane working pulls the shared line low
    assign rb_drive_low = (|pgm_busy) | (|ers_busy);
endmodule

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;
    localparam int DW = 16, AW = 19, SW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_act = 1'b0;
    logic [0:0]    rd_plane = '0;
    logic [SW-1:0] rd_sector = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] array_data = '0;
    logic [1:0]    pgm_busy = '0, ers_busy = '0;
    logic [AW-1:0] pgm_addr = '0;
    logic [DW-1:0] pgm_data = '0;
    logic          sus_valid = 1'b0;
    logic [0:0]    sus_plane = '0;
    logic [SW-1:0] sus_sector = '0;
    logic [DW-1:0] rd_data;
    logic          rb_drive_low;

    int checks = 0, errors = 0;
    bit m6 [2];
    bit m2 [2];
    bit finished = 0;

    always #10 clk = ~clk;

    flash_status_gen u_dut (
        .clk(clk), .rst(rst), .rd_act(rd_act), .rd_plane(rd_plane),
        .rd_sector(rd_sector), .rd_addr(rd_addr), .array_data(array_data),
        .pgm_busy(pgm_busy), .ers_busy(ers_busy), .pgm_addr(pgm_addr),
        .pgm_data(pgm_data), .sus_valid(sus_valid), .sus_plane(sus_plane),
        .sus_sector(sus_sector), .rd_data(rd_data), .rb_drive_low(rb_drive_low)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit sus_in(input int p);
        return sus_valid && (int'(sus_plane) == p);
    endfunction

    function automatic logic [DW-1:0] expect_word(input int p,
            input logic [SW-1:0] sec, input logic [AW-1:0] a, input logic [DW-1:0] arr);
        logic [DW-1:0] d = arr;
        if (sus_in(p) && sec == sus_sector) begin
            d[7] = 1'b1; d[6] = 1'b1; d[2] = m2[p];
        end else if (ers_busy[p]) begin
            d[7] = 1'b0; d[6] = m6[p]; d[2] = m2[p];
        end else if (pgm_busy[p]) begin
            d[7] = (a == pgm_addr) ? ~pgm_data[7] : arr[7];
            d[6] = m6[p];
            d[2] = sus_in(p) ? m2[p] : 1'b1;
        end
        return d;
    endfunction

    task automatic set_state(input bit p0, input bit e0, input bit p1, input bit e1,
                             input bit sv, input bit sp, input logic [SW-1:0] ss,
                             input logic [AW-1:0] pa, input logic [DW-1:0] pd);
        @(negedge clk);
        pgm_busy = {p1, p0}; ers_busy = {e1, e0};
        sus_valid = sv; sus_plane = sp; sus_sector = ss;
        pgm_addr = pa; pgm_data = pd;
        @(posedge clk);
        for (int p = 0; p < 2; p++) begin
            if (!(pgm_busy[p] || ers_busy[p])) m6[p] = 0;
            if (!(ers_busy[p] || sus_in(p))) m2[p] = 0;
        end
    endtask

    task automatic do_read(input bit p, input logic [SW-1:0] sec,
                           input logic [AW-1:0] a, input logic [DW-1:0] arr,
                           input int hold, input string tag);
        logic [DW-1:0] exp;
        @(negedge clk);
        rd_plane = p; rd_sector = sec; rd_addr = a; array_data = arr; rd_act = 1'b1;
        #2;
        exp = expect_word(p, sec, a, arr);
        chk(rd_data === exp, tag, rd_data, exp);
        chk(rb_drive_low === ((|pgm_busy) | (|ers_busy)), "R1",
            {15'd0, rb_drive_low}, {15'd0, (|pgm_busy) | (|ers_busy)});
        for (int h = 0; h < hold; h++) begin
            @(negedge clk); #2;
            chk(rd_data === exp, {tag, " R12 hold"}, rd_data, exp);
        end
        @(negedge clk);
        rd_act = 1'b0;
        @(posedge clk);
        if (pgm_busy[p] || ers_busy[p]) m6[p] = ~m6[p];
        if (ers_busy[p] || sus_in(int'(p))) m2[p] = ~m2[p];
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #2;
        chk(rb_drive_low === 1'b0, "R1 reset", {15'd0, rb_drive_low}, 16'd0);
        do_read(0, 5'd1, 19'h00010, 16'hA5C3, 0, "R8 idle after reset");

        // program in plane 0, read polled address
        set_state(1, 0, 0, 0, 0, 0, 0, 19'h00123, 16'h0080);
        do_read(0, 5'd0, 19'h00123, 16'hFFFF, 0, "R2 R5 R6 R13 first poll");
        do_read(0, 5'd0, 19'h00123, 16'hFFFF, 0, "R2 R5 second poll");
        do_read(0, 5'd0, 19'h00200, 16'h1234, 0, "R3 other address");
        do_read(1, 5'd9, 19'h40000, 16'h5A5A, 0, "R8 R12 other plane");
        do_read(0, 5'd0, 19'h00123, 16'hFFFF, 2, "R5 R12 after other plane, held");

        // erase in plane 1 while plane 0 goes idle
        set_state(0, 0, 0, 1, 0, 0, 0, 19'h0, 16'h0);
        do_read(1, 5'd10, 19'h48000, 16'hFFFF, 0, "R4 R7 erase first");
        do_read(1, 5'd10, 19'h48000, 16'hFFFF, 0, "R4 R7 erase second");
        do_read(0, 5'd2, 19'h00400, 16'h0F0F, 0, "R8 R11 idle plane");

        // new program on plane 0: toggles restart at 0
        set_state(1, 0, 0, 1, 0, 0, 0, 19'h00500, 16'h007F);
        do_read(0, 5'd2, 19'h00500, 16'h00FF, 0, "R11 R2 restart");

        // suspend erase in plane 1 sector 3
        set_state(0, 0, 0, 0, 1, 1, 5'd3, 19'h0, 16'h0);
        do_read(1, 5'd3, 19'h18000, 16'h0000, 0, "R9 suspended sector");
        do_read(1, 5'd3, 19'h18000, 16'h0000, 0, "R9 R7 suspended again");
        do_read(1, 5'd4, 19'h20000, 16'h3C3C, 0, "R8 non-suspended sector");
        chk(rb_drive_low === 1'b0, "R1 suspended idle", {15'd0, rb_drive_low}, 16'd0);

        // program in the suspended plane: collision of R9 and R10
        set_state(0, 0, 1, 0, 1, 1, 5'd3, 19'h20010, 16'h0000);
        do_read(1, 5'd4, 19'h20010, 16'h0000, 0, "R10 pgm with suspend");
        do_read(1, 5'd4, 19'h20010, 16'h0000, 0, "R10 pgm with suspend 2");
        do_read(1, 5'd3, 19'h18000, 16'h0000, 0, "R9 hit over pgm");

        // random mix
        for (int i = 0; i < 400; i++) begin
            if ($urandom % 4 == 0) begin
                bit p0, e0, p1, e1, sv, sp;
                int r0, r1;
                r0 = $urandom % 3; r1 = $urandom % 3;
                p0 = (r0 == 1); e0 = (r0 == 2);
                p1 = (r1 == 1); e1 = (r1 == 2);
                sv = ($urandom % 3 == 0); sp = $urandom % 2;
                if (sv && sp == 0) e0 = 0;
                if (sv && sp == 1) e1 = 0;
                set_state(p0, e0, p1, e1, sv, sp, SW'($urandom % 4),
                          AW'($urandom % 8), DW'($urandom));
            end
            begin
                bit rp;
                logic [AW-1:0] ra;
                rp = $urandom % 2;
                ra = ($urandom % 2 == 0) ? pgm_addr : AW'($urandom % 8);
                do_read(rp, SW'($urandom % 4), ra, DW'($urandom),
                        ($urandom % 5 == 0) ? 1 : 0, "R2 R3 R4 R5 R7 R8 R9 R10 R13 random");
            end
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule